// File: doc/BRIEF.md
# Multi-Mode Load Address Generator

This block turns one load request into an effective memory address. A one-cycle start pulse carries an addressing mode code, two register-file indices (base and index) and a sign-extended immediate. The block reads the base and index registers through two combinational read ports of an external register file, computes the address and returns it with a one-cycle done pulse, together with an alignment flag and an error flag for an unused mode code.

Most modes finish in one cycle. The pointer-chasing mode needs one word from memory: the block asks a simple request/valid memory port for the word stored at the base register's address, waits as long as the memory needs, and returns that word as the address. The two auto-modify modes return the base value unchanged and, in the same cycle as done, offer a one-cycle writeback of the base stepped by one word. The caller applies that writeback to its register file.

Top module: `ldaddr_gen`

## Requirements
- R1: Mode code 0 (absolute) reports the immediate as the address, with done high in the cycle after the start is taken.
- R2: Mode code 1 (register indirect) reports the base register contents as the address one cycle after start.
- R3: Mode code 2 (displaced) reports base register plus immediate, modulo 2^32, one cycle after start.
- R4: Mode code 3 (indexed) reports base register plus index register, modulo 2^32, one cycle after start.
- R5: Mode code 4 (memory indirect) raises the memory request in the cycle after start with the request address equal to the base register contents, holds request and address steady until valid is seen, and raises done in the cycle after valid with the returned word as the address.
- R6: Mode code 5 (auto-increment) reports the old base value as the address and, with done, pulses writeback enable with the base index and the old base plus 4.
- R7: Mode code 6 (auto-decrement) reports the old base value as the address and, with done, pulses writeback enable with the base index and the old base minus 4, modulo 2^32.
- R8: Mode code 7 is illegal: done rises one cycle after start with the error flag high, address zero, no writeback and no memory request; the error flag is low for every other mode.
- R9: The misaligned flag, valid with done, is high exactly when bits 1:0 of the reported address are non-zero; the address is still reported.
- R10: The busy flag is high from the cycle after a memory-indirect start until done; a start while busy is ignored and produces no done and no result.
- R11: Writeback enable is high only together with done, for exactly one cycle, and only in modes 5 and 6; done itself lasts one cycle.
- R12: While reset is asserted and just after it, done, busy, memory request and writeback enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| mode_i | input | 3 | Addressing mode code |
| base_sel_i | input | 5 | Base register index |
| ofs_sel_i | input | 5 | Index register index |
| imm_i | input | 32 | Sign-extended immediate or offset |
| rf_a_addr_o | output | 5 | Register read port A index (base) |
| rf_a_data_i | input | 32 | Register read port A data |
| rf_b_addr_o | output | 5 | Register read port B index (index) |
| rf_b_data_i | input | 32 | Register read port B data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_valid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| done_o | output | 1 | Result valid pulse |
| ea_o | output | 32 | Effective address |
| misalign_o | output | 1 | Address not word-aligned |
| illegal_o | output | 1 | Illegal mode code |
| busy_o | output | 1 | Waiting on memory |
| wb_en_o | output | 1 | Base writeback enable |
| wb_sel_o | output | 5 | Base writeback register index |
| wb_data_o | output | 32 | Base writeback value |

## Verification
The bench aims at wrap-around: a negative displacement past zero, auto-decrement from zero and auto-increment from the top word, where a design that dropped the carry or sign would report a wrong address or writeback. It lets the memory stall for several cycles and fires a start in the middle of the wait; a design that accepted it would emit an extra done or overwrite the fetched address, and one that released the request early would lose the word. Index and base naming the same register, misaligned bases and fetched words, and the illegal code are also driven, catching a flag tied to the wrong address or a writeback leaking out of a mode that must not modify.

// File: rtl/ldag_pkg.sv
package ldag_pkg;
  typedef enum logic [2:0] {
    AM_ABS  = 3'd0,
    AM_RIND = 3'd1,
    AM_DISP = 3'd2,
    AM_IDX  = 3'd3,
    AM_MIND = 3'd4,
    AM_AINC = 3'd5,
    AM_ADEC = 3'd6,
    AM_BAD  = 3'd7
  } amode_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/ldag_rst_sync.sv
module ldag_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/ldag_calc.sv
module ldag_calc
  import ldag_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic [2:0]    mode,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] ofs_val,
  input  logic [AW-1:0] imm,
  output logic [AW-1:0] ea,
  output logic          needs_mem,
  output logic          mod_en,
  output logic [AW-1:0] mod_val,
  output logic          bad
);
  localparam logic [AW-1:0] STEP_W = AW'(STEP);

  always_comb begin
    ea        = '0;
    needs_mem = 1'b0;
    mod_en    = 1'b0;
    mod_val   = base_val;
    bad       = 1'b0;
    unique case (amode_e'(mode))
      AM_ABS:  ea = imm;
      AM_RIND: ea = base_val;
      AM_DISP: ea = base_val + imm;
      AM_IDX:  ea = base_val + ofs_val;
      AM_MIND: needs_mem = 1'b1;
      AM_AINC: begin
        ea      = base_val;
        mod_en  = 1'b1;
        mod_val = base_val + STEP_W;
      end
      AM_ADEC: begin
        ea      = base_val;
        mod_en  = 1'b1;
        mod_val = base_val - STEP_W;
      end
      AM_BAD:  bad = 1'b1;
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/ldag_seq.sv
module ldag_seq
  import ldag_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          needs_mem,
  input  logic [AW-1:0] ptr_addr,
  input  logic          mem_valid,
  output logic          accept,
  output logic          mem_take,
  output logic          busy,
  output logic [AW-1:0] req_addr
);
  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          addr_ld;

  assign accept   = start && (state_q == SQ_IDLE);
  assign busy     = (state_q == SQ_WAIT);
  assign mem_take = busy && mem_valid;
  assign addr_ld  = accept && needs_mem;
  assign req_addr = addr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (addr_ld)   state_d = SQ_WAIT;
      SQ_WAIT: if (mem_valid) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_ld) addr_q <= ptr_addr;
  end

  // request and its address stay put across a stall
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_valid |=> busy && $stable(addr_q));
  // start while waiting does not restart or cancel the fetch
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |-> !accept);
endmodule

// File: rtl/ldaddr_gen.sv
module ldaddr_gen
  import ldag_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned RF_DEPTH = 32,
  parameter int unsigned STEP     = 4,
  localparam int unsigned RW      = $clog2(RF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic [RW-1:0] base_sel_i,
  input  logic [RW-1:0] ofs_sel_i,
  input  logic [AW-1:0] imm_i,
  output logic [RW-1:0] rf_a_addr_o,
  input  logic [AW-1:0] rf_a_data_i,
  output logic [RW-1:0] rf_b_addr_o,
  input  logic [AW-1:0] rf_b_data_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic [AW-1:0] ea_o,
  output logic          misalign_o,
  output logic          illegal_o,
  output logic          busy_o,
  output logic          wb_en_o,
  output logic [RW-1:0] wb_sel_o,
  output logic [AW-1:0] wb_data_o
);
  logic          rst_q_n;
  logic [AW-1:0] c_ea, c_mod;
  logic          c_mem, c_mod_en, c_bad;
  logic          accept, mem_take, busy;
  logic          one_shot;
  logic          done_d, wb_en_d;
  logic [AW-1:0] ea_d;
  logic          bad_d, mis_d;
  logic          done_q, wb_en_q, bad_q, mis_q;
  logic [AW-1:0] ea_q, wb_data_q;
  logic [RW-1:0] wb_sel_q;

  ldag_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign rf_a_addr_o = base_sel_i;
  assign rf_b_addr_o = ofs_sel_i;

  ldag_calc #(.AW(AW), .STEP(STEP)) u_calc (
    .mode      (mode_i),
    .base_val  (rf_a_data_i),
    .ofs_val   (rf_b_data_i),
    .imm       (imm_i),
    .ea        (c_ea),
    .needs_mem (c_mem),
    .mod_en    (c_mod_en),
    .mod_val   (c_mod),
    .bad       (c_bad)
  );

  ldag_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .start     (start_i),
    .needs_mem (c_mem),
    .ptr_addr  (rf_a_data_i),
    .mem_valid (mem_valid_i),
    .accept    (accept),
    .mem_take  (mem_take),
    .busy      (busy),
    .req_addr  (mem_addr_o)
  );

  // next-state of the result registers
  always_comb begin
    one_shot = accept && !c_mem;
    done_d   = one_shot || mem_take;
    wb_en_d  = one_shot && c_mod_en;
    ea_d     = mem_take ? mem_rdata_i : c_ea;
    bad_d    = one_shot && c_bad;
    mis_d    = |ea_d[1:0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      done_q  <= 1'b0;
      wb_en_q <= 1'b0;
    end else begin
      done_q  <= done_d;
      wb_en_q <= wb_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ea_q  <= '0;
      bad_q <= 1'b0;
      mis_q <= 1'b0;
    end else if (done_d) begin
      ea_q  <= ea_d;
      bad_q <= bad_d;
      mis_q <= mis_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wb_sel_q  <= '0;
      wb_data_q <= '0;
    end else if (wb_en_d) begin
      wb_sel_q  <= base_sel_i;
      wb_data_q <= c_mod;
    end
  end

  assign mem_req_o  = busy;
  assign busy_o     = busy;
  assign done_o     = done_q;
  assign ea_o       = ea_q;
  assign misalign_o = mis_q;
  assign illegal_o  = bad_q;
  assign wb_en_o    = wb_en_q;
  assign wb_sel_o   = wb_sel_q;
  assign wb_data_o  = wb_data_q;

  p_single_done_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    start_i && !busy_o && (mode_i != 3'd4) |=> done_o);
  p_mind_result_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_req_o && mem_valid_i |=> done_o && (ea_o == $past(mem_rdata_i)));
  p_bad_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_o && illegal_o |-> !wb_en_o && (ea_o == '0));
  p_mis_flag_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_o |-> (misalign_o == (ea_o[1:0] != 2'b00)));
  p_wb_with_done_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    wb_en_o |-> done_o);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_o && !mem_req_o |=> !done_o || $past(start_i));
  p_wb_pulse_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    wb_en_o |=> !wb_en_o || $past(start_i));
  p_quiet_r12: assert property (@(posedge clk)
    !rst_q_n |-> !done_o && !busy_o && !mem_req_o && !wb_en_o);
endmodule

// File: tb/test_ldaddr_gen.sv
module test_ldaddr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [4:0]  bsel = '0, osel = '0;
  logic [31:0] imm = '0;
  logic [4:0]  ra, rb;
  logic [31:0] rda, rdb;
  logic        mreq, mvalid = 1'b0;
  logic [31:0] maddr, mrdata = '0;
  logic        done, mis, ill, busy, wben;
  logic [31:0] ea, wbdata;
  logic [4:0]  wbsel;
  logic [31:0] rf [32];
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  assign rda = rf[ra];
  assign rdb = rf[rb];

  ldaddr_gen i_ldaddr_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
    .base_sel_i(bsel), .ofs_sel_i(osel), .imm_i(imm),
    .rf_a_addr_o(ra), .rf_a_data_i(rda), .rf_b_addr_o(rb), .rf_b_data_i(rdb),
    .mem_req_o(mreq), .mem_addr_o(maddr), .mem_valid_i(mvalid), .mem_rdata_i(mrdata),
    .done_o(done), .ea_o(ea), .misalign_o(mis), .illegal_o(ill), .busy_o(busy),
    .wb_en_o(wben), .wb_sel_o(wbsel), .wb_data_o(wbdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      wrap_up();
    end
  end

  function automatic logic [31:0] exp_ea(input logic [2:0] m, input logic [31:0] b,
                                         input logic [31:0] x, input logic [31:0] i);
    case (m)
      3'd0: return i;
      3'd1: return b;
      3'd2: return b + i;
      3'd3: return b + x;
      3'd5, 3'd6: return b;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] m);
    case (m)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3"; 3'd3: return "R4";
      3'd4: return "R5"; 3'd5: return "R6"; 3'd6: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic single_op(input logic [2:0] m, input logic [4:0] b, input logic [4:0] x,
                           input logic [31:0] i);
    logic [31:0] e, bv;
    bv = rf[b];
    e  = exp_ea(m, bv, rf[x], i);
    mode = m; bsel = b; osel = x; imm = i; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag(m), " done"}, 32'(done), 32'd1);
    chk({tag(m), " ea"}, ea, e);
    chk("R9 misalign", 32'(mis), 32'(e[1:0] != 2'b00));
    chk("R8 illegal flag", 32'(ill), 32'(m == 3'd7));
    chk("R11 wb_en", 32'(wben), 32'(m == 3'd5 || m == 3'd6));
    if (m == 3'd5 || m == 3'd6) begin
      chk({tag(m), " wb_sel"}, 32'(wbsel), 32'(b));
      chk({tag(m), " wb_data"}, wbdata, (m == 3'd5) ? bv + 32'd4 : bv - 32'd4);
      if (wben) rf[wbsel] = wbdata;
    end
    if (m == 3'd7) chk("R8 no mem req", 32'(mreq), 32'd0);
    @(negedge clk);
    chk("R11 done one cycle", 32'(done), 32'd0);
    chk("R11 wb_en one cycle", 32'(wben), 32'd0);
  endtask

  task automatic mind_op(input logic [4:0] b, input int lat, input logic [31:0] word,
                         input logic poke);
    logic [31:0] bv;
    bv = rf[b];
    mode = 3'd4; bsel = b; osel = 5'd0; imm = $urandom; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R5 req after start", 32'(mreq), 32'd1);
    chk("R5 req addr", maddr, bv);
    chk("R10 busy", 32'(busy), 32'd1);
    chk("R5 no early done", 32'(done), 32'd0);
    if (poke) begin
      mode = 3'd0; imm = 32'hDEAD_BEE0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10 start ignored no done", 32'(done), 32'd0);
      chk("R10 still busy", 32'(busy), 32'd1);
    end
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk("R5 req held", 32'(mreq), 32'd1);
      chk("R5 addr held", maddr, bv);
    end
    mvalid = 1'b1; mrdata = word;
    @(negedge clk);
    mvalid = 1'b0; mrdata = $urandom;
    chk("R5 done", 32'(done), 32'd1);
    chk("R5 ea", ea, word);
    chk("R9 misalign", 32'(mis), 32'(word[1:0] != 2'b00));
    chk("R11 no wb", 32'(wben), 32'd0);
    chk("R10 busy clear", 32'(busy), 32'd0);
    chk("R5 req clear", 32'(mreq), 32'd0);
    @(negedge clk);
    chk("R10 ignored start left no result", 32'(done), 32'd0);
  endtask

  initial begin
    int unsigned s;
    s = $urandom(32'h0BAD_5EED);
    for (int r = 0; r < 32; r++) rf[r] = $urandom & ((r % 3 == 0) ? 32'hFFFF_FFFF : 32'hFFFF_FFFC);
    repeat (3) @(negedge clk);
    chk("R12 reset done", 32'(done), 32'd0);
    chk("R12 reset busy", 32'(busy), 32'd0);
    chk("R12 reset req", 32'(mreq), 32'd0);
    chk("R12 reset wb_en", 32'(wben), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 after reset done", 32'(done), 32'd0);

    // directed corners
    single_op(3'd0, 5'd3, 5'd4, 32'h0000_1002);
    rf[7] = 32'h0000_0010;
    single_op(3'd2, 5'd7, 5'd0, 32'hFFFF_FFE0);
    single_op(3'd3, 5'd9, 5'd9, 32'h0);
    rf[10] = 32'h0;
    single_op(3'd6, 5'd10, 5'd1, 32'h0);
    chk("R7 rf model wrap", rf[10], 32'hFFFF_FFFC);
    rf[11] = 32'hFFFF_FFFC;
    single_op(3'd5, 5'd11, 5'd1, 32'h0);
    chk("R6 rf model wrap", rf[11], 32'h0);
    rf[12] = 32'h0000_0103;
    single_op(3'd1, 5'd12, 5'd1, 32'h0);
    single_op(3'd7, 5'd12, 5'd1, 32'h1234_5678);
    mind_op(5'd5, 0, 32'h8000_0002, 1'b0);
    mind_op(5'd6, 4, 32'h4000_0000, 1'b1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 7));
      if (m == 3'd4)
        mind_op(5'($urandom), $urandom_range(0, 5), $urandom, 1'($urandom));
      else
        single_op(m, 5'($urandom), 5'($urandom), $urandom);
    end
    wrap_up();
  end
endmodule